// File: doc/BRIEF.md
# Lane-Splittable Multiply-Accumulate Slice

This block is a three-stage pipelined arithmetic slice. A signed 25-bit operand, optionally summed first with a second 25-bit operand in a pre-adder, is multiplied by a signed 18-bit operand. The sign-extended product, or a 48-bit operand taken straight from the inputs when the multiplier is bypassed, feeds a 48-bit adder and logic stage. That stage writes a 48-bit result register, which also acts as the accumulator.

The adder can run as one 48-bit unit, as two independent 24-bit lanes, or as four independent 12-bit lanes. Each lane reports its own carry. Control inputs arrive with every operand set, so the operation, the lane split, the multiplier bypass and the pre-adder can all change from cycle to cycle. A valid flag travels down the pipeline beside the data.

The block suits symmetric FIR taps (pre-adder followed by accumulate), packed small-word arithmetic, and lane-wise counters.

Top module: `simd_mac_slice`

## Requirements
- R1: An operand set sampled with `in_valid` high on a rising edge produces `out_valid` high, with the updated `out_p` and `out_carry`, after the second rising edge that follows it. That is three registers in all, counting the input register. `out_valid` is low in every other cycle.
- R2: With `use_mult`=1, operand X is the signed product of `pre` and `in_b`, sign-extended to 48 bits. `pre` is `in_a` when `pre_en`=0. When `pre_en`=1 it is `in_a`+`in_d`, wrapped to 25 bits two's complement.
- R3: With `use_mult`=0, operand X is `in_x`. Operand Y is always `in_y`.
- R4: `opcode` 0 gives X+Y and `opcode` 1 gives X−Y, both computed per lane.
- R5: `lane_mode` 0 (and 3) selects one 48-bit lane, 1 selects two 24-bit lanes, and 2 selects four 12-bit lanes. No carry or borrow crosses a lane boundary.
- R6: `out_carry[i]` holds the carry out of 12-bit segment i when that segment is the top of a lane, and 0 otherwise. One lane uses bit 3; two lanes use bits 1 and 3. For subtraction the carry is 1 when no borrow occurs. Load and logic operations clear all carry bits.
- R7: `opcode` 2 gives P+X and `opcode` 3 gives P−X per lane, where P is the current value of `out_p`. Back-to-back operations chain correctly.
- R8: `opcode` 4 loads X into the accumulator unchanged.
- R9: `opcode` 5 adds 1 to each lane of P and `opcode` 6 subtracts 1 from each lane, with per-lane wraparound.
- R10: Opcodes 16 to 25 give, in order: X&Y, X|Y, X^Y, ~(X&Y), ~(X|Y), ~(X^Y), X&~Y, X|~Y, ~X, and X.
- R11: Opcodes 7 to 15 and 26 to 31 leave `out_p` and `out_carry` unchanged, although `out_valid` still pulses.
- R12: A synchronous active-high `rst` clears `out_p`, `out_carry` and `out_valid`. While no valid result arrives, `out_p` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set valid this cycle |
| opcode | input | 5 | Operation code |
| lane_mode | input | 2 | Lane split of the adder |
| use_mult | input | 1 | 1: X from the multiplier, 0: X from in_x |
| pre_en | input | 1 | Add in_d to in_a before the multiplier |
| in_a | input | 25 | Signed multiplier operand |
| in_d | input | 25 | Signed pre-adder operand |
| in_b | input | 18 | Signed multiplier operand |
| in_x | input | 48 | Wide X operand used in bypass |
| in_y | input | 48 | Wide Y operand |
| out_valid | output | 1 | Result valid |
| out_p | output | 48 | Result / accumulator |
| out_carry | output | 4 | Per-lane carry out |

## Verification
The assertions check the following on every cycle:
- the three-register valid latency;
- that `out_p` holds while no result arrives;
- that carry bits stay zero in segments that are not the top of a lane;
- that a bypassed load copies the operand sampled three edges earlier;
- that reserved codes leave the result and carry untouched;
- the cleared state after reset.

The arithmetic itself can only be shown by the bench's scenarios. These cover:
- pre-adder wrap and signed products at the operand extremes;
- lane isolation when every lane overflows at once;
- chained accumulation that uses the previous result;
- counter wraparound inside a 12-bit lane;
- the ten logic functions.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

    localparam int DEF_A_W = 25;
    localparam int DEF_B_W = 18;
    localparam int DEF_P_W = 48;
    localparam int N_SEG   = 4;

    typedef enum logic [1:0] {
        LN_ONE  = 2'b00,
        LN_TWO  = 2'b01,
        LN_FOUR = 2'b10,
        LN_ALT  = 2'b11
    } lane_e;

    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_ACC    = 5'd2,
        OP_ACCSUB = 5'd3,
        OP_LOAD   = 5'd4,
        OP_UP     = 5'd5,
        OP_DOWN   = 5'd6,
        OP_AND    = 5'd16,
        OP_OR     = 5'd17,
        OP_XOR    = 5'd18,
        OP_NAND   = 5'd19,
        OP_NOR    = 5'd20,
        OP_XNOR   = 5'd21,
        OP_ANDN   = 5'd22,
        OP_ORN    = 5'd23,
        OP_NOTX   = 5'd24,
        OP_PASSX  = 5'd25
    } op_e;

    typedef struct packed {
        logic  valid;
        op_e   op;
        lane_e lane;
        logic  use_mult;
        logic  pre_en;
    } ctrl_t;

    // True when segment seg is the most significant segment of its lane.
    function automatic logic lane_top(lane_e lm, int seg, int n_seg);
        case (lm)
            LN_FOUR: return 1'b1;
            LN_TWO:  return (seg == n_seg / 2 - 1) || (seg == n_seg - 1);
            default: return (seg == n_seg - 1);
        endcase
    endfunction

    function automatic logic is_logic_op(op_e op);
        return (op >= OP_AND) && (op <= OP_PASSX);
    endfunction

endpackage

// File: rtl/simd_premult.sv
module simd_premult
    import simd_mac_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W,
    parameter int P_W = DEF_P_W
) (
    input  logic [A_W-1:0] a_i,
    input  logic [A_W-1:0] d_i,
    input  logic [B_W-1:0] b_i,
    input  logic           pre_en_i,
    output logic [P_W-1:0] prod_o
);
    localparam int PR_W = A_W + B_W;

    logic [A_W-1:0]         pre_sum;
    logic signed [A_W-1:0]  pre_s;
    logic signed [B_W-1:0]  b_s;
    logic signed [PR_W-1:0] prod_s;

    always_comb begin
        pre_sum = a_i + d_i;
        pre_s   = pre_en_i ? signed'(pre_sum) : signed'(a_i);
        b_s     = signed'(b_i);
        prod_s  = pre_s * b_s;
        prod_o  = P_W'(prod_s);
    end

endmodule

// File: rtl/simd_seg_addsub.sv
module simd_seg_addsub
    import simd_mac_pkg::*;
#(
    parameter int P_W   = DEF_P_W,
    parameter int N_SG  = N_SEG
) (
    input  logic [P_W-1:0]  lhs_i,
    input  logic [P_W-1:0]  rhs_i,
    input  logic            sub_i,
    input  lane_e           lane_i,
    output logic [P_W-1:0]  sum_o,
    output logic [N_SG-1:0] cout_o
);
    localparam int SEG_W = P_W / N_SG;

    logic [P_W-1:0]  rhs_m;
    logic [N_SG:1]   chain;
    logic [N_SG-1:0] cin;

    assign rhs_m = sub_i ? ~rhs_i : rhs_i;

    for (genvar g = 0; g < N_SG; g++) begin : g_seg
        if (g == 0) begin : g_first
            assign cin[g] = sub_i;
        end else begin : g_rest
            assign cin[g] = lane_top(lane_i, g - 1, N_SG) ? sub_i : chain[g];
        end
        assign {chain[g+1], sum_o[g*SEG_W +: SEG_W]} =
            {1'b0, lhs_i[g*SEG_W +: SEG_W]} +
            {1'b0, rhs_m[g*SEG_W +: SEG_W]} +
            {{SEG_W{1'b0}}, cin[g]};
        assign cout_o[g] = lane_top(lane_i, g, N_SG) ? chain[g+1] : 1'b0;
    end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
    import simd_mac_pkg::*;
#(
    parameter int P_W = DEF_P_W
) (
    input  op_e            op_i,
    input  logic [P_W-1:0] x_i,
    input  logic [P_W-1:0] y_i,
    output logic [P_W-1:0] z_o
);
    always_comb begin
        case (op_i)
            OP_AND:   z_o = x_i & y_i;
            OP_OR:    z_o = x_i | y_i;
            OP_XOR:   z_o = x_i ^ y_i;
            OP_NAND:  z_o = ~(x_i & y_i);
            OP_NOR:   z_o = ~(x_i | y_i);
            OP_XNOR:  z_o = ~(x_i ^ y_i);
            OP_ANDN:  z_o = x_i & ~y_i;
            OP_ORN:   z_o = x_i | ~y_i;
            OP_NOTX:  z_o = ~x_i;
            OP_PASSX: z_o = x_i;
            default:  z_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_mac_slice.sv
module simd_mac_slice
    import simd_mac_pkg::*;
#(
    parameter int A_W = DEF_A_W,
    parameter int B_W = DEF_B_W,
    parameter int P_W = DEF_P_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        opcode,
    input  logic [1:0]        lane_mode,
    input  logic              use_mult,
    input  logic              pre_en,
    input  logic [A_W-1:0]    in_a,
    input  logic [A_W-1:0]    in_d,
    input  logic [B_W-1:0]    in_b,
    input  logic [P_W-1:0]    in_x,
    input  logic [P_W-1:0]    in_y,
    output logic              out_valid,
    output logic [P_W-1:0]    out_p,
    output logic [N_SEG-1:0]  out_carry
);
    localparam int SEG_W = P_W / N_SEG;

    // stage 1: input registers
    ctrl_t          s1_ctrl;
    logic [A_W-1:0] s1_a, s1_d;
    logic [B_W-1:0] s1_b;
    logic [P_W-1:0] s1_x, s1_y;

    // stage 2: product register
    ctrl_t          s2_ctrl;
    logic [P_W-1:0] s2_prod, s2_x, s2_y;

    // stage 3: accumulator / result
    logic [P_W-1:0]   p_q;
    logic [N_SEG-1:0] c_q;
    logic             v_q;

    logic [P_W-1:0]   prod_c;
    logic [P_W-1:0]   opx, lhs, rhs, sum, lz, ones;
    logic [N_SEG-1:0] cout;
    logic             sub;
    logic [P_W-1:0]   p_nxt;
    logic [N_SEG-1:0] c_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctrl <= '0;
            s1_a    <= '0;
            s1_d    <= '0;
            s1_b    <= '0;
            s1_x    <= '0;
            s1_y    <= '0;
        end else begin
            s1_ctrl.valid    <= in_valid;
            s1_ctrl.op       <= op_e'(opcode);
            s1_ctrl.lane     <= lane_e'(lane_mode);
            s1_ctrl.use_mult <= use_mult;
            s1_ctrl.pre_en   <= pre_en;
            s1_a             <= in_a;
            s1_d             <= in_d;
            s1_b             <= in_b;
            s1_x             <= in_x;
            s1_y             <= in_y;
        end
    end

    simd_premult #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mult (
        .a_i      (s1_a),
        .d_i      (s1_d),
        .b_i      (s1_b),
        .pre_en_i (s1_ctrl.pre_en),
        .prod_o   (prod_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_ctrl <= '0;
            s2_prod <= '0;
            s2_x    <= '0;
            s2_y    <= '0;
        end else begin
            s2_ctrl <= s1_ctrl;
            s2_prod <= prod_c;
            s2_x    <= s1_x;
            s2_y    <= s1_y;
        end
    end

    // one in the least significant bit of every lane
    always_comb begin
        ones = '0;
        for (int i = 0; i < N_SEG; i++) begin
            if (i == 0 || lane_top(s2_ctrl.lane, i - 1, N_SEG))
                ones[i*SEG_W] = 1'b1;
        end
    end

    assign opx = s2_ctrl.use_mult ? s2_prod : s2_x;

    always_comb begin
        lhs = opx;
        rhs = s2_y;
        sub = 1'b0;
        case (s2_ctrl.op)
            OP_SUB:    sub = 1'b1;
            OP_ACC:    begin lhs = p_q; rhs = opx; end
            OP_ACCSUB: begin lhs = p_q; rhs = opx; sub = 1'b1; end
            OP_UP:     begin lhs = p_q; rhs = ones; end
            OP_DOWN:   begin lhs = p_q; rhs = ones; sub = 1'b1; end
            default:   ;
        endcase
    end

    simd_seg_addsub #(.P_W(P_W), .N_SG(N_SEG)) u_add (
        .lhs_i  (lhs),
        .rhs_i  (rhs),
        .sub_i  (sub),
        .lane_i (s2_ctrl.lane),
        .sum_o  (sum),
        .cout_o (cout)
    );

    simd_logic_unit #(.P_W(P_W)) u_logic (
        .op_i (s2_ctrl.op),
        .x_i  (opx),
        .y_i  (s2_y),
        .z_o  (lz)
    );

    always_comb begin
        case (s2_ctrl.op)
            OP_ADD, OP_SUB, OP_ACC, OP_ACCSUB, OP_UP, OP_DOWN: begin
                p_nxt = sum;
                c_nxt = cout;
            end
            OP_LOAD: begin
                p_nxt = opx;
                c_nxt = '0;
            end
            default: begin
                if (is_logic_op(s2_ctrl.op)) begin
                    p_nxt = lz;
                    c_nxt = '0;
                end else begin
                    p_nxt = p_q;
                    c_nxt = c_q;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
            c_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= s2_ctrl.valid;
            if (s2_ctrl.valid) begin
                p_q <= p_nxt;
                c_q <= c_nxt;
            end
        end
    end

    assign out_valid = v_q;
    assign out_p     = p_q;
    assign out_carry = c_q;

endmodule

// File: rtl/simd_mac_checker.sv
module simd_mac_checker
    import simd_mac_pkg::*;
#(
    parameter int P_W = DEF_P_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [4:0]       opcode,
    input logic [1:0]       lane_mode,
    input logic             use_mult,
    input logic [P_W-1:0]   in_x,
    input logic             out_valid,
    input logic [P_W-1:0]   out_p,
    input logic [N_SEG-1:0] out_carry
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        since_rst == 2'd3 |-> out_valid == $past(in_valid, 3));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |-> out_p == $past(out_p));

    a_r12_reset_clear: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd0) |-> (out_p == '0 && out_carry == '0 && !out_valid));

    a_r6_carry_one_lane: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid &&
         ($past(lane_mode, 3) == 2'd0 || $past(lane_mode, 3) == 2'd3))
        |-> out_carry[2:0] == 3'b000);

    a_r6_carry_two_lane: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(lane_mode, 3) == 2'd1)
        |-> (out_carry[0] == 1'b0 && out_carry[2] == 1'b0));

    a_r8_load_bypass: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(opcode, 3) == 5'd4 &&
         !$past(use_mult, 3))
        |-> (out_p == $past(in_x, 3) && out_carry == '0));

    a_r11_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid &&
         (($past(opcode, 3) >= 5'd7 && $past(opcode, 3) <= 5'd15) ||
          $past(opcode, 3) >= 5'd26))
        |-> (out_p == $past(out_p) && out_carry == $past(out_carry)));

endmodule

bind simd_mac_slice simd_mac_checker #(.P_W(P_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .lane_mode (lane_mode),
    .use_mult  (use_mult),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_p     (out_p),
    .out_carry (out_carry)
);

// File: tb/simd_mac_slice_test.sv
module simd_mac_slice_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [1:0]  lane_mode = '0;
    logic        use_mult = 1'b0;
    logic        pre_en = 1'b0;
    logic [24:0] in_a = '0;
    logic [24:0] in_d = '0;
    logic [17:0] in_b = '0;
    logic [47:0] in_x = '0;
    logic [47:0] in_y = '0;
    logic        out_valid;
    logic [47:0] out_p;
    logic [3:0]  out_carry;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [47:0] mdl_p = '0;
    logic [3:0]  mdl_c = '0;

    logic [47:0] q_p[$];
    logic [3:0]  q_c[$];
    int          q_due[$];
    string       q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    simd_mac_slice uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .lane_mode(lane_mode), .use_mult(use_mult), .pre_en(pre_en),
        .in_a(in_a), .in_d(in_d), .in_b(in_b), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_p(out_p), .out_carry(out_carry)
    );

    task automatic check(input bit ok, input string tag, input logic [51:0] act,
                         input logic [51:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] operand_x(bit um, bit pe, logic [24:0] a,
                                              logic [24:0] d, logic [17:0] b,
                                              logic [47:0] x);
        logic signed [24:0] pa;
        longint prod;
        if (!um) return x;
        pa = pe ? (a + d) : a;
        prod = longint'(pa) * longint'($signed(b));
        return prod[47:0];
    endfunction

    // per-lane add or subtract: model written from R4..R6
    task automatic lane_arith(input logic [47:0] l, input logic [47:0] r,
                              input bit sub, input logic [1:0] lm,
                              output logic [47:0] res, output logic [3:0] cy);
        int nl;
        int w;
        longint unsigned mask, lv, rv, s;
        nl = (lm == 2'd1) ? 2 : (lm == 2'd2) ? 4 : 1;
        w = 48 / nl;
        mask = (64'd1 << w) - 1;
        res = '0;
        cy = '0;
        for (int k = 0; k < nl; k++) begin
            lv = (longint'(l) >> (k * w)) & mask;
            rv = (longint'(r) >> (k * w)) & mask;
            if (sub) begin
                s = (lv - rv) & mask;
                cy[(k + 1) * (4 / nl) - 1] = (lv >= rv);
            end else begin
                s = lv + rv;
                cy[(k + 1) * (4 / nl) - 1] = s[w];
                s = s & mask;
            end
            res = res | 48'(s << (k * w));
        end
    endtask

    function automatic logic [47:0] lane_one(logic [1:0] lm);
        if (lm == 2'd1) return 48'h000001_000001;
        if (lm == 2'd2) return 48'h001_001_001_001;
        return 48'h1;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [1:0] lm, input bit um,
                         input bit pe, input logic [24:0] a, input logic [24:0] d,
                         input logic [17:0] b, input logic [47:0] x,
                         input logic [47:0] y, input string tag);
        logic [47:0] ox, res;
        logic [3:0]  cy;
        ox = operand_x(um, pe, a, d, b, x);
        res = mdl_p;
        cy = mdl_c;
        case (op)
            5'd0: lane_arith(ox, y, 1'b0, lm, res, cy);
            5'd1: lane_arith(ox, y, 1'b1, lm, res, cy);
            5'd2: lane_arith(mdl_p, ox, 1'b0, lm, res, cy);
            5'd3: lane_arith(mdl_p, ox, 1'b1, lm, res, cy);
            5'd4: begin res = ox; cy = '0; end
            5'd5: lane_arith(mdl_p, lane_one(lm), 1'b0, lm, res, cy);
            5'd6: lane_arith(mdl_p, lane_one(lm), 1'b1, lm, res, cy);
            5'd16: begin res = ox & y; cy = '0; end
            5'd17: begin res = ox | y; cy = '0; end
            5'd18: begin res = ox ^ y; cy = '0; end
            5'd19: begin res = ~(ox & y); cy = '0; end
            5'd20: begin res = ~(ox | y); cy = '0; end
            5'd21: begin res = ~(ox ^ y); cy = '0; end
            5'd22: begin res = ox & ~y; cy = '0; end
            5'd23: begin res = ox | ~y; cy = '0; end
            5'd24: begin res = ~ox; cy = '0; end
            5'd25: begin res = ox; cy = '0; end
            default: ;
        endcase
        mdl_p = res;
        mdl_c = cy;
        q_p.push_back(res);
        q_c.push_back(cy);
        q_due.push_back(cyc + 3);
        q_tag.push_back(tag);
        in_valid = 1'b1; opcode = op; lane_mode = lm; use_mult = um; pre_en = pe;
        in_a = a; in_d = d; in_b = b; in_x = x; in_y = y;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_x = ~in_x;
        opcode = 5'd4;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_p.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", 52'(out_p), 52'h0);
            end else begin
                logic [47:0] ep;
                logic [3:0]  ec;
                int          due;
                string       tg;
                ep = q_p.pop_front();
                ec = q_c.pop_front();
                due = q_due.pop_front();
                tg = q_tag.pop_front();
                check(due == cyc, "R1 latency", 52'(cyc), 52'(due));
                check(out_p == ep, tg, 52'(out_p), 52'(ep));
                check(out_carry == ec, {tg, " carry R6"}, 52'(out_carry), 52'(ec));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1 watchdog expired", 52'(cyc), 52'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_p == '0 && out_carry == '0 && !out_valid, "R12 reset state",
              52'({out_carry, out_p}), 52'h0);
        rst = 1'b0;
        @(negedge clk);

        // R2: pre-adder and signed product
        drive(5'd0, 2'd0, 1'b1, 1'b1, -25'sd1000, 25'sd300, -18'sd7, 48'h0, 48'h0, "R2 preadd product");
        drive(5'd0, 2'd0, 1'b1, 1'b0, 25'sd12345, 25'sd999, -18'sd131072, 48'h0, 48'h5, "R2 product no preadd");
        drive(5'd0, 2'd0, 1'b1, 1'b1, 25'h0FFFFFF, 25'd1, 18'sd3, 48'h0, 48'h0, "R2 preadd wrap");
        // R3 R4 R6: bypass, one lane, carry out of bit 47
        drive(5'd0, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'hFFFF_FFFF_FFFF, 48'h1, "R3 R4 add carry");
        drive(5'd1, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'h5, 48'h7, "R4 sub borrow");
        // R5: four lanes, every lane overflows, no propagation
        drive(5'd0, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, "R5 four lane add");
        drive(5'd1, 2'd1, 1'b0, 1'b0, '0, '0, '0, 48'h000010_000000, 48'h000001_000001, "R5 two lane sub");
        drive(5'd0, 2'd3, 1'b0, 1'b0, '0, '0, '0, 48'h000000_FFFFFF, 48'h1, "R5 mode3 one lane");
        // R7 R8: load then chained accumulate
        drive(5'd4, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'h0000_0000_1000, 48'h0, "R8 load");
        drive(5'd2, 2'd0, 1'b1, 1'b1, 25'sd20, 25'sd5, -18'sd4, 48'h0, 48'h0, "R7 acc product");
        drive(5'd2, 2'd0, 1'b1, 1'b0, -25'sd16777216, 25'sd0, 18'sd131071, 48'h0, 48'h0, "R7 acc extreme");
        drive(5'd3, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'h123, 48'h0, "R7 acc sub");
        drive(5'd2, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h800_800_800_800, 48'h0, "R7 acc four lane");
        // R9: counters with lane wrap
        drive(5'd4, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h000_FFF_000_7FF, 48'h0, "R8 load counter");
        drive(5'd5, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h0, 48'h0, "R9 count up");
        drive(5'd6, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h0, 48'h0, "R9 count down");
        drive(5'd6, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h0, 48'h0, "R9 count down wrap");
        drive(5'd5, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'h0, 48'h0, "R9 count up wide");
        // R10: the ten logic functions
        for (int f = 16; f <= 25; f++)
            drive(5'(f), 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'hF0F0_CCCC_AAAA,
                  48'hFF00_F0F0_3C3C, "R10 logic function");
        // R11: reserved codes hold result and carry
        drive(5'd0, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'hFFFF_FFFF_FFFF, 48'h2, "R11 set carry");
        drive(5'd7, 2'd2, 1'b0, 1'b0, '0, '0, '0, 48'h1234, 48'h1, "R11 reserved 7");
        drive(5'd28, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'hFFFF, 48'hFFFF, "R11 reserved 28");
        // R12: idle cycles hold the result
        idle(6);
        check(out_p == mdl_p && !out_valid, "R12 idle hold", 52'(out_p), 52'(mdl_p));
        drive(5'd2, 2'd0, 1'b0, 1'b0, '0, '0, '0, 48'h10, 48'h0, "R7 acc after gap");
        idle(6);
        check(q_p.size() == 0, "R1 all results seen", 52'(q_p.size()), 52'h0);
        // R12: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_p == '0 && out_carry == '0 && !out_valid, "R12 reset clears",
              52'({out_carry, out_p}), 52'h0);
        rst = 1'b0;
        mdl_p = '0;
        mdl_c = '0;
        @(negedge clk);
        drive(5'd5, 2'd1, 1'b0, 1'b0, '0, '0, '0, 48'h0, 48'h0, "R9 R12 count after reset");
        idle(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule